// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a blocking data cache that sits between a processor request port and a word-wide memory port. Each 32-bit byte address is split into a tag, a line index and a word offset. The index selects exactly one line. A request that finds a valid line with a matching tag completes one cycle after it is accepted, and it causes no memory traffic.

When the tag does not match, or the line is empty, the processor is held. If the line being replaced holds modified data, its four words are first written to memory at the line's old address. The four words of the requested block are then read in ascending order. After that the access is retried and completes as a hit.

Writes allocate on a miss and then update only the cached copy. Each write marks the line dirty, and memory is written only when that line is later evicted. Memory requests are held until memory acknowledges them, so memory latency may differ from word to word.

Top module: `wbcache_ctrl`

## Requirements
- R1: After reset every line is empty, `cpu_ready` and `mem_req` are low, and the first access to any address fetches its block from memory.
- R2: Byte address bits 3:2 select the word within a line, bits 13:4 select one of 1024 lines, and bits 31:14 form the tag. Bits 1:0 are ignored. Every memory request carries the index of the pending request in bits 13:4.
- R3: An access to a valid line with a matching tag completes with `cpu_ready` high in the second cycle after `cpu_valid` is first seen. It makes no memory request, and a read returns the stored word on `cpu_rdata`.
- R4: A write hit replaces only the addressed word in the cache and marks the line dirty. It makes no memory write, and a later read of that address returns the new data.
- R5: A miss on an empty or clean line makes exactly four memory reads, at the block's base address plus 0, 4, 8 and 12 in that order. The access then completes.
- R6: A miss on a dirty line first makes exactly four memory writes of the old line to its old tag and index, with word offsets ascending. It makes no write after the first refill read. The evicted data is returned when that address is read again.
- R7: A write miss fetches the whole block and then merges the write word. The other words keep their memory values, and the line is dirty afterwards.
- R8: `mem_req` stays high with stable `mem_addr`, `mem_we` and write data until `mem_ack` is seen. Each word takes as many cycles as memory needs.
- R9: The cache is blocking. `cpu_ready` is low for the whole of a miss sequence. It is a single-cycle completion pulse that never coincides with `mem_req`, and memory is requested only while `cpu_valid` is high.
- R10: Two addresses with the same index and different tags evict each other, and this also holds at the highest index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Request pending; held with stable fields until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid while `cpu_ready` is high |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the current memory word |

## Verification
The path that is hardest to reach from the ports is a dirty eviction that must be followed by a refill. Reaching it needs a write to one line, then an access with the same index and a different tag. The evicted data is only seen when the first address is read back after a second eviction.

The stimulus builds such chains at a low index and at index 1023. It includes a write miss that makes a freshly filled line dirty. The memory model's latency rotates from word to word, so acknowledges fall on different cycles within a burst. A reference model of the tags and of flat memory predicts, for every access, the read data, the number of memory writes and reads, and their addresses.

// File: rtl/cache_pkg.sv
package cache_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COMPARE = 2'd1,
      ST_WRBACK  = 2'd2,
      ST_FILL    = 2'd3
   } cache_state_e;

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
   parameter int ADDR_W    = 32,
   parameter int TAG_BITS  = 18,
   parameter int IDX_BITS  = 10,
   parameter int WORD_BITS = 2,
   parameter int BYTE_BITS = 2
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [TAG_BITS-1:0]  tag,
   output logic [IDX_BITS-1:0]  idx,
   output logic [WORD_BITS-1:0] word
);
   localparam int WORD_LO = BYTE_BITS;
   localparam int IDX_LO  = BYTE_BITS + WORD_BITS;
   localparam int TAG_LO  = IDX_LO + IDX_BITS;

   logic unused_byte_bits;

   assign word = addr[WORD_LO +: WORD_BITS];
   assign idx  = addr[IDX_LO +: IDX_BITS];
   assign tag  = addr[TAG_LO +: TAG_BITS];
   assign unused_byte_bits = ^addr[BYTE_BITS-1:0];

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
   parameter int LINES     = 1024,
   parameter int IDX_BITS  = 10,
   parameter int TAG_BITS  = 18,
   parameter int WORDS     = 4,
   parameter int WORD_BITS = 2,
   parameter int DATA_W    = 32,
   parameter int LINE_W    = WORDS * DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_BITS-1:0]  rd_idx,
   output logic                 rd_valid,
   output logic                 rd_dirty,
   output logic [TAG_BITS-1:0]  rd_tag,
   output logic [LINE_W-1:0]    rd_line,
   input  logic                 wr_en,
   input  logic [IDX_BITS-1:0]  wr_idx,
   input  logic [WORD_BITS-1:0] wr_word,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 wr_dirty,
   input  logic                 inst_en,
   input  logic [IDX_BITS-1:0]  inst_idx,
   input  logic [TAG_BITS-1:0]  inst_tag
);
   logic [LINE_W-1:0]   data_q [LINES];
   logic [TAG_BITS-1:0] tag_q  [LINES];
   logic [LINES-1:0]    valid_q;
   logic [LINES-1:0]    dirty_q;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int w = 0; w < WORDS; w++) begin
            if (int'(wr_word) == w) begin
               data_q[wr_idx][w*DATA_W +: DATA_W] <= wr_data;
            end
         end
      end
      if (inst_en) begin
         tag_q[inst_idx] <= inst_tag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (inst_en) begin
            valid_q[inst_idx] <= 1'b1;
            dirty_q[inst_idx] <= 1'b0;
         end
         if (wr_en && wr_dirty) begin
            dirty_q[wr_idx] <= 1'b1;
         end
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_line  = data_q[rd_idx];

endmodule

// File: rtl/cache_ctrl_fsm.sv
module cache_ctrl_fsm
   import cache_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int TAG_BITS  = 18,
   parameter int IDX_BITS  = 10,
   parameter int WORDS     = 4,
   parameter int WORD_BITS = 2,
   parameter int BYTE_BITS = 2,
   parameter int LINE_W    = WORDS * DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_valid,
   input  logic                 cpu_we,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [DATA_W-1:0]    cpu_wdata,
   output logic                 cpu_ready,
   output logic [DATA_W-1:0]    cpu_rdata,
   output logic [ADDR_W-1:0]    req_addr,
   input  logic [TAG_BITS-1:0]  req_tag,
   input  logic [IDX_BITS-1:0]  req_idx,
   input  logic [WORD_BITS-1:0] req_word,
   input  logic                 lk_valid,
   input  logic                 lk_dirty,
   input  logic [TAG_BITS-1:0]  lk_tag,
   input  logic [LINE_W-1:0]    lk_line,
   output logic                 st_wr_en,
   output logic [WORD_BITS-1:0] st_wr_word,
   output logic [DATA_W-1:0]    st_wr_data,
   output logic                 st_wr_dirty,
   output logic                 st_inst_en,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata,
   input  logic                 mem_ack
);
   localparam logic [WORD_BITS-1:0] LAST_WORD = WORD_BITS'(WORDS - 1);

   cache_state_e          state_q;
   logic [WORD_BITS-1:0]  cnt_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [DATA_W-1:0]     wdata_q;
   logic                  we_q;
   logic                  hit;
   logic                  last;
   logic [DATA_W-1:0]     word_cand [WORDS];
   logic [DATA_W-1:0]     sel_req_word;
   logic [DATA_W-1:0]     sel_cnt_word;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign word_cand[w] = lk_line[w*DATA_W +: DATA_W];
   end

   always_comb begin
      sel_req_word = '0;
      sel_cnt_word = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (int'(req_word) == w) sel_req_word = word_cand[w];
         if (int'(cnt_q) == w)    sel_cnt_word = word_cand[w];
      end
   end

   assign hit      = lk_valid && (lk_tag == req_tag);
   assign last     = (cnt_q == LAST_WORD);
   assign req_addr = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cpu_valid) begin
                  addr_q  <= cpu_addr;
                  wdata_q <= cpu_wdata;
                  we_q    <= cpu_we;
                  state_q <= ST_COMPARE;
               end
            end
            ST_COMPARE: begin
               cnt_q <= '0;
               if (hit) begin
                  state_q <= ST_IDLE;
               end else if (lk_valid && lk_dirty) begin
                  state_q <= ST_WRBACK;
               end else begin
                  state_q <= ST_FILL;
               end
            end
            ST_WRBACK: begin
               if (mem_ack) begin
                  cnt_q <= last ? '0 : cnt_q + 1'b1;
                  if (last) state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  cnt_q <= last ? '0 : cnt_q + 1'b1;
                  if (last) state_q <= ST_COMPARE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cpu_ready   = 1'b0;
      cpu_rdata   = sel_req_word;
      st_wr_en    = 1'b0;
      st_wr_word  = req_word;
      st_wr_data  = wdata_q;
      st_wr_dirty = 1'b0;
      st_inst_en  = 1'b0;
      mem_req     = 1'b0;
      mem_we      = 1'b0;
      mem_addr    = '0;
      mem_wdata   = '0;
      case (state_q)
         ST_COMPARE: begin
            if (hit) begin
               cpu_ready   = 1'b1;
               st_wr_en    = we_q;
               st_wr_dirty = we_q;
            end
         end
         ST_WRBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {lk_tag, req_idx, cnt_q, {BYTE_BITS{1'b0}}};
            mem_wdata = sel_cnt_word;
         end
         ST_FILL: begin
            mem_req    = 1'b1;
            mem_addr   = {req_tag, req_idx, cnt_q, {BYTE_BITS{1'b0}}};
            st_wr_en   = mem_ack;
            st_wr_word = cnt_q;
            st_wr_data = mem_rdata;
            st_inst_en = mem_ack && last;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/wbcache_ctrl.sv
module wbcache_ctrl #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LINES  = 1024,
   parameter int WORDS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int BYTE_BITS = $clog2(DATA_W / 8);
   localparam int WORD_BITS = $clog2(WORDS);
   localparam int IDX_BITS  = $clog2(LINES);
   localparam int OFF_BITS  = BYTE_BITS + WORD_BITS;
   localparam int TAG_BITS  = ADDR_W - IDX_BITS - OFF_BITS;
   localparam int LINE_W    = WORDS * DATA_W;

   if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if ((WORDS & (WORDS - 1)) != 0 || WORDS < 2) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 16");
   end
   if (TAG_BITS < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   logic [ADDR_W-1:0]    req_addr;
   logic [TAG_BITS-1:0]  req_tag;
   logic [IDX_BITS-1:0]  req_idx;
   logic [WORD_BITS-1:0] req_word;
   logic                 lk_valid;
   logic                 lk_dirty;
   logic [TAG_BITS-1:0]  lk_tag;
   logic [LINE_W-1:0]    lk_line;
   logic                 st_wr_en;
   logic [WORD_BITS-1:0] st_wr_word;
   logic [DATA_W-1:0]    st_wr_data;
   logic                 st_wr_dirty;
   logic                 st_inst_en;

   cache_addr_split #(
      .ADDR_W(ADDR_W), .TAG_BITS(TAG_BITS), .IDX_BITS(IDX_BITS),
      .WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS)
   ) u_split (
      .addr(req_addr), .tag(req_tag), .idx(req_idx), .word(req_word)
   );

   cache_line_store #(
      .LINES(LINES), .IDX_BITS(IDX_BITS), .TAG_BITS(TAG_BITS),
      .WORDS(WORDS), .WORD_BITS(WORD_BITS), .DATA_W(DATA_W), .LINE_W(LINE_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(req_idx), .rd_valid(lk_valid), .rd_dirty(lk_dirty),
      .rd_tag(lk_tag), .rd_line(lk_line),
      .wr_en(st_wr_en), .wr_idx(req_idx), .wr_word(st_wr_word),
      .wr_data(st_wr_data), .wr_dirty(st_wr_dirty),
      .inst_en(st_inst_en), .inst_idx(req_idx), .inst_tag(req_tag)
   );

   cache_ctrl_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_BITS(TAG_BITS),
      .IDX_BITS(IDX_BITS), .WORDS(WORDS), .WORD_BITS(WORD_BITS),
      .BYTE_BITS(BYTE_BITS), .LINE_W(LINE_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .req_addr(req_addr), .req_tag(req_tag), .req_idx(req_idx),
      .req_word(req_word),
      .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag),
      .lk_line(lk_line),
      .st_wr_en(st_wr_en), .st_wr_word(st_wr_word), .st_wr_data(st_wr_data),
      .st_wr_dirty(st_wr_dirty), .st_inst_en(st_inst_en),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int IDX_LO   = 4,
   parameter int IDX_BITS = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);

   // R9
   ready_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);

   // R9
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   // R9
   mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_valid);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && (!mem_we || $stable(mem_wdata))));

   // R2
   mem_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && mem_req) |-> (mem_addr[IDX_LO +: IDX_BITS] == cpu_addr[IDX_LO +: IDX_BITS]));

   // R6
   no_wb_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> !(mem_req && mem_we));

endmodule

bind wbcache_ctrl cache_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_LO(OFF_BITS), .IDX_BITS(IDX_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
   .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/wbcache_ctrl_bench.sv
module wbcache_ctrl_bench;

   typedef struct {
      bit          chk_data;
      logic [31:0] rdata;
      bit          hit;
      int          n_wr;
      int          n_rd;
      logic [31:0] wb_base;
      logic [31:0] fill_base;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0;
   logic        cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   exp_t        sb_q[$];
   int          mon_chk = 0, mon_fail = 0;
   int          mem_chk = 0, mem_fail = 0;
   int          drv_chk = 0, drv_fail = 0;
   int          tot_wr = 0, tot_rd = 0;
   int          base_wr = 0, base_rd = 0;
   int          wait_c = 0;
   bit          done = 1'b0;

   bit          ref_v [int];
   logic [17:0] ref_t [int];
   bit          ref_d [int];
   logic [31:0] gold  [int];
   logic [31:0] memv  [int];

   always #4 clk = ~clk;

   wbcache_ctrl u_wbcache_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack)
   );

   function automatic logic [31:0] init_word(logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
   endfunction

   function automatic logic [31:0] gold_rd(logic [31:0] a);
      if (gold.exists(int'(a))) return gold[int'(a)];
      return init_word(a);
   endfunction

   function automatic logic [31:0] mem_rd(logic [31:0] a);
      if (memv.exists(int'(a))) return memv[int'(a)];
      return init_word(a);
   endfunction

   // Memory model with rotating latency; checks R5, R6 and R8 addressing.
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         wait_c = 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (wait_c < ((tot_wr + tot_rd) % 3)) begin
            wait_c = wait_c + 1;
         end else begin
            wait_c = 0;
            mem_chk = mem_chk + 1;
            if (mem_we) begin
               if (sb_q.size() == 0 || tot_rd != base_rd ||
                   mem_addr != sb_q[0].wb_base + 32'(4 * (tot_wr - base_wr))) begin
                  mem_fail = mem_fail + 1;
                  $display("FAIL R6 write-back address/order: actual %h expected %h",
                           mem_addr, (sb_q.size() > 0) ?
                           sb_q[0].wb_base + 32'(4 * (tot_wr - base_wr)) : 32'h0);
               end
               memv[int'(mem_addr)] = mem_wdata;
               tot_wr = tot_wr + 1;
            end else begin
               if (sb_q.size() == 0 ||
                   mem_addr != sb_q[0].fill_base + 32'(4 * (tot_rd - base_rd))) begin
                  mem_fail = mem_fail + 1;
                  $display("FAIL R5 R8 refill address: actual %h expected %h",
                           mem_addr, (sb_q.size() > 0) ?
                           sb_q[0].fill_base + 32'(4 * (tot_rd - base_rd)) : 32'h0);
               end
               mem_rdata <= mem_rd(mem_addr);
               tot_rd = tot_rd + 1;
            end
            mem_ack <= 1'b1;
         end
      end
   end

   // Monitor: pops the scoreboard on each completion (R3 R4 R5 R6 R7 R10).
   always @(negedge clk) begin
      if (rst_n && cpu_ready) begin
         if (sb_q.size() == 0) begin
            mon_chk = mon_chk + 1;
            mon_fail = mon_fail + 1;
            $display("FAIL R9 completion with no pending request: actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            mon_chk = mon_chk + 1;
            if (e.chk_data && cpu_rdata !== e.rdata) begin
               mon_fail = mon_fail + 1;
               $display("FAIL %s read data: actual %h expected %h", e.tag, cpu_rdata, e.rdata);
            end
            mon_chk = mon_chk + 1;
            if ((tot_wr - base_wr) != e.n_wr || (tot_rd - base_rd) != e.n_rd) begin
               mon_fail = mon_fail + 1;
               $display("FAIL %s memory traffic wr/rd: actual %0d/%0d expected %0d/%0d",
                        e.tag, tot_wr - base_wr, tot_rd - base_rd, e.n_wr, e.n_rd);
            end
            base_wr = tot_wr;
            base_rd = tot_rd;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==",
                  mon_chk + mem_chk + drv_chk, mon_fail + mem_fail + drv_fail);
         $finish;
      end
   endtask

   // Driver: predicts with the reference model, pushes, then runs the handshake.
   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                         input string tag);
      exp_t        e;
      int          idx;
      logic [17:0] tg;
      logic [31:0] wa;
      int          lat;
      idx = int'(a[13:4]);
      tg  = a[31:14];
      wa  = {a[31:2], 2'b00};
      e.tag = tag;
      e.chk_data = !we;
      e.hit = ref_v.exists(idx) && ref_v[idx] && (ref_t[idx] == tg);
      e.fill_base = {tg, a[13:4], 4'h0};
      e.wb_base = '0;
      e.n_wr = 0;
      e.n_rd = 0;
      if (!e.hit) begin
         e.n_rd = 4;
         if (ref_v.exists(idx) && ref_v[idx] && ref_d[idx]) begin
            e.n_wr = 4;
            e.wb_base = {ref_t[idx], a[13:4], 4'h0};
         end
         ref_v[idx] = 1'b1;
         ref_t[idx] = tg;
         ref_d[idx] = 1'b0;
      end
      e.rdata = gold_rd(wa);
      if (we) begin
         ref_d[idx] = 1'b1;
         gold[int'(wa)] = d;
      end
      sb_q.push_back(e);
      @(posedge clk); #1;
      cpu_valid = 1'b1;
      cpu_we    = we;
      cpu_addr  = a;
      cpu_wdata = d;
      lat = 0;
      do begin
         @(negedge clk);
         lat = lat + 1;
      end while (!cpu_ready && !done);
      // R9: a hit completes at the second cycle; a miss holds ready low longer
      drv_chk = drv_chk + 1;
      if (e.hit ? (lat != 2) : (lat <= 2 + e.n_rd)) begin
         drv_fail = drv_fail + 1;
         $display("FAIL R9 %s completion cycle: actual %0d expected %s", tag, lat,
                  e.hit ? "2" : "above 6");
      end
      @(posedge clk); #1;
      cpu_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mem_fail = mem_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      drv_chk = drv_chk + 1;
      if (cpu_ready !== 1'b0 || mem_req !== 1'b0) begin
         drv_fail = drv_fail + 1;
         $display("FAIL R1 reset outputs ready/req: actual %b/%b expected 0/0",
                  cpu_ready, mem_req);
      end
      // R1 R5 R3: word address replay 22 26 22 26 16 3 16 18 (byte = word*4)
      access(1'b0, 32'd88,  '0, "R1");
      access(1'b0, 32'd104, '0, "R5");
      access(1'b0, 32'd88,  '0, "R3");
      access(1'b0, 32'd104, '0, "R3");
      access(1'b0, 32'd64,  '0, "R5");
      access(1'b0, 32'd12,  '0, "R5");
      access(1'b0, 32'd64,  '0, "R3");
      access(1'b0, 32'd72,  '0, "R3");
      // R4: write hit stays in cache, then reads back
      access(1'b1, 32'h0000_0058, 32'hDEAD_BEEF, "R4");
      access(1'b0, 32'h0000_0058, '0, "R4");
      // R2: byte offset bits ignored
      access(1'b0, 32'h0000_005B, '0, "R2");
      // R6: dirty eviction by same-index address, then evicted data returns
      access(1'b0, 32'h0000_4058, '0, "R6");
      access(1'b0, 32'h0000_0058, '0, "R6");
      // R7: write miss allocates then merges
      access(1'b1, 32'h0000_805C, 32'h1111_2222, "R7");
      access(1'b0, 32'h0000_8050, '0, "R7");
      access(1'b0, 32'h0000_805C, '0, "R7");
      access(1'b0, 32'h0000_0054, '0, "R7");
      access(1'b0, 32'h0000_805C, '0, "R7");
      // R10: conflicts at the highest index with extreme tags
      access(1'b1, 32'hFFFF_FFFC, 32'hCAFE_F00D, "R10");
      access(1'b0, 32'h0000_3FF0, '0, "R10");
      access(1'b1, 32'h0000_3FF4, 32'h0BAD_CAFE, "R10");
      access(1'b0, 32'hFFFF_FFFC, '0, "R10");
      access(1'b0, 32'h0000_3FF4, '0, "R10");
      access(1'b0, 32'hFFFF_FFF0, '0, "R2");
      // R8: back-to-back misses across many latencies
      for (int i = 0; i < 6; i++) begin
         access(1'b1, 32'h0010_0200 + 32'(i * 32'h4000), 32'(i * 7 + 3), "R8");
      end
      for (int i = 0; i < 6; i++) begin
         access(1'b0, 32'h0010_0200 + 32'(i * 32'h4000), '0, "R8");
      end
      repeat (4) @(posedge clk);
      drv_chk = drv_chk + 1;
      if (sb_q.size() != 0) begin
         drv_fail = drv_fail + 1;
         $display("FAIL R9 pending items at end: actual %0d expected 0", sb_q.size());
      end
      finish_run();
   end

endmodule